// File: doc/BRIEF.md
# Split-phase remote word proxy

This block sits between a processor's local memory port and a network message interface. It serves an address window that stands for a global shared memory. Each access names a 64-bit word and carries, in its top two address bits, a command telling the proxy whether this is the start of a remote operation or its conclusion. A start (issue) access records the request in a small table of outstanding operations, queues it for its destination node and releases the processor in the same cycle. A conclusion (complete) access waits until the remote reply for that word has come back, and then returns the data or confirms the write.

The global word address is split into a destination node and an offset on that node. Requests bound for one node are gathered in a per-node buffer. The buffer goes out as a single message when it holds its maximum number of requests, or when a timer started by its oldest request runs out, whichever happens first. Replies arrive one word per cycle and carry the table index (tag) that was sent with the request, so they may return in any order.

Top module: `remote_word_proxy`

## Requirements
- R1: After reset the table and all node buffers are empty. No message is offered (tx_valid=0), and cpu_ack is 0 while cpu_req is 0.
- R2: cpu_addr[AW-1:AW-2] is the command: 2'b01 is issue and 2'b10 is complete. The codes 2'b00 and 2'b11 are acknowledged in the same cycle with cpu_err=1, and they start nothing, so no message follows them.
- R3: An issue access is acknowledged in the same cycle with cpu_err=0 and cpu_rdata=0 if the table has a free entry and its node has no message waiting to go out. Its request is then queued.
- R4: Word address gw=cpu_addr[AW-3:0] maps to node gw[NB-1:0] and to offset gw[AW-3:NB]. A queued request is the EW-bit word {we, tag, offset, data}, with the MSB first. The tag is the lowest free table index. data holds cpu_wdata for a write and 0 for a read.
- R5: A read complete stalls (cpu_ack=0) until a reply carrying its entry's tag has been taken. It is then acknowledged with cpu_rdata equal to the reply data and cpu_err=0, and its entry is freed. A repeated complete to the same word then reports an error.
- R6: A write complete stalls until the reply for its tag has arrived. It is then acknowledged with cpu_err=0 and cpu_rdata=0.
- R7: A complete access to a word that has no outstanding entry is acknowledged in the same cycle with cpu_err=1.
- R8: While all DEPTH table entries are outstanding, an issue access is held off (cpu_ack=0). It is accepted once a complete access has freed an entry.
- R9: When a node buffer reaches BATCH requests, a message is offered on the next cycle with tx_count=BATCH. Slot k of the message is tx_words[k*EW +: EW], and the slots follow the order in which the requests were issued.
- R10: A node buffer that holds fewer than BATCH requests is offered exactly TMO clock edges after the edge that accepted its first request.
- R11: A reply is matched to its entry by rx_tag alone. A reply for one entry does not release a complete access that waits on another entry, and replies may arrive in any order.
- R12: While tx_valid=1 and tx_ready=0, the signals tx_node, tx_count and tx_words stay unchanged. When no message is held, the lowest-numbered pending node goes first. An issue access to a node whose message is pending is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_we | input | 1 | 1 for a write access, 0 for a read access |
| cpu_addr | input | AW | Command in the top two bits, global word address below them |
| cpu_wdata | input | DW | Write data for a write issue |
| cpu_ack | output | 1 | Access accepted or answered in this cycle |
| cpu_err | output | 1 | Error response, valid together with cpu_ack |
| cpu_rdata | output | DW | Read data for a read complete |
| tx_valid | output | 1 | An outgoing message is offered |
| tx_ready | input | 1 | The network takes the offered message |
| tx_node | output | NB | Destination node of the message |
| tx_count | output | CW | Number of valid slots in the message |
| tx_words | output | BATCH*EW | Request slots, with slot 0 in the low bits |
| rx_valid | input | 1 | A reply word is present |
| rx_tag | input | TAGW | Table tag of the reply |
| rx_data | input | DW | Reply data |

## Verification
The main function is driven with several patterns:
- A read and a write aimed at the same node. This shows that a full batch leaves at once and packs its slots in issue order.
- A lone request. This isolates the timeout, which is checked for the exact edge on which the message appears.
- A fill of all table entries spread across every node, with the network held off. This separates table back-pressure from batch back-pressure, and shows the difference between holding a message and choosing a new one by priority.
- Replies returned in the opposite order to the issues, while a complete access waits. This shows that matching is done by tag and not by arrival order.

// File: rtl/rwp_pkg.sv
`timescale 1ns/1ps
package rwp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_ISSUE    = 2'b01,
    CMD_COMPLETE = 2'b10,
    CMD_RSVD     = 2'b11
  } rwp_cmd_e;
endpackage

// File: rtl/rwp_decode.sv
`timescale 1ns/1ps
module rwp_decode
  import rwp_pkg::*;
#(
  parameter int AW = 30,
  parameter int NB = 2
) (
  input  logic [AW-1:0]      addr,
  output rwp_cmd_e           cmd,
  output logic [AW-3:0]      gword,
  output logic [NB-1:0]      node,
  output logic [AW-3-NB:0]   offs
);
  assign cmd   = rwp_cmd_e'(addr[AW-1:AW-2]);
  assign gword = addr[AW-3:0];
  assign node  = gword[NB-1:0];
  assign offs  = gword[AW-3:NB];
endmodule

// File: rtl/rwp_table.sv
`timescale 1ns/1ps
module rwp_table #(
  parameter int DEPTH = 4,
  parameter int GW    = 28,
  parameter int DW    = 64,
  parameter int TAGW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_en,
  input  logic [GW-1:0]   alloc_addr,
  input  logic            free_en,
  input  logic [TAGW-1:0] free_idx,
  input  logic            rsp_en,
  input  logic [TAGW-1:0] rsp_tag,
  input  logic [DW-1:0]   rsp_data,
  input  logic [GW-1:0]   look_addr,
  output logic            full,
  output logic [TAGW-1:0] alloc_idx,
  output logic            hit,
  output logic [TAGW-1:0] hit_idx,
  output logic            hit_done,
  output logic [DW-1:0]   hit_data
);
  logic [DEPTH-1:0] vld_q, vld_d, done_q, done_d, match;
  logic [GW-1:0]    adr_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];

  always_comb begin
    alloc_idx = '0;
    hit_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      match[i] = vld_q[i] && (adr_q[i] == look_addr);
      if (!vld_q[i]) alloc_idx = TAGW'(i);
      if (match[i])  hit_idx   = TAGW'(i);
    end
  end

  assign full     = &vld_q;
  assign hit      = |match;
  assign hit_done = done_q[hit_idx];
  assign hit_data = dat_q[hit_idx];

  always_comb begin
    vld_d  = vld_q;
    done_d = done_q;
    if (free_en) vld_d[free_idx] = 1'b0;
    if (alloc_en) begin
      vld_d[alloc_idx]  = 1'b1;
      done_d[alloc_idx] = 1'b0;
    end
    if (rsp_en && vld_q[rsp_tag]) done_d[rsp_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      done_q <= '0;
    end else begin
      vld_q  <= vld_d;
      done_q <= done_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (alloc_en && alloc_idx == TAGW'(e)) adr_q[e] <= alloc_addr;
      if (rsp_en && rsp_tag == TAGW'(e))     dat_q[e] <= rsp_data;
    end
  end
endmodule

// File: rtl/rwp_batcher.sv
`timescale 1ns/1ps
module rwp_batcher #(
  parameter int NB    = 2,
  parameter int BATCH = 2,
  parameter int TMO   = 8,
  parameter int EW    = 93,
  parameter int NODES = 1 << NB,
  parameter int CW    = $clog2(BATCH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_en,
  input  logic [NB-1:0]       push_node,
  input  logic [EW-1:0]       push_entry,
  input  logic                tx_ready,
  output logic [NODES-1:0]    pend,
  output logic                tx_valid,
  output logic [NB-1:0]       tx_node,
  output logic [CW-1:0]       tx_count,
  output logic [BATCH*EW-1:0] tx_words
);
  localparam int TW = $clog2(TMO + 1);

  logic [CW-1:0]       cnt_a [NODES];
  logic [BATCH*EW-1:0] buf_a [NODES];
  logic [NB-1:0]       pri_sel, sel, sel_q;
  logic                hold_q;

  always_comb begin
    pri_sel = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (pend[n]) pri_sel = NB'(n);
  end

  assign sel      = hold_q ? sel_q : pri_sel;
  assign tx_valid = |pend;
  assign tx_node  = sel;
  assign tx_count = cnt_a[sel];
  assign tx_words = buf_a[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      hold_q <= tx_valid && !tx_ready;
      if (tx_valid) sel_q <= sel;
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic [CW-1:0]       cnt_q, cnt_d;
    logic [TW-1:0]       tmr_q, tmr_d;
    logic [BATCH*EW-1:0] slots_q;
    logic                push_here, flush;

    assign push_here = push_en && (push_node == NB'(n));
    assign flush     = tx_valid && tx_ready && (sel == NB'(n));
    assign pend[n]   = (cnt_q == CW'(BATCH)) || (tmr_q >= TW'(TMO));
    assign cnt_a[n]  = cnt_q;
    assign buf_a[n]  = slots_q;

    always_comb begin
      cnt_d = cnt_q;
      tmr_d = tmr_q;
      if (flush) begin
        cnt_d = '0;
        tmr_d = '0;
      end else if (push_here) begin
        cnt_d = cnt_q + CW'(1);
        if (cnt_q == '0)          tmr_d = '0;
        else if (tmr_q < TW'(TMO)) tmr_d = tmr_q + TW'(1);
      end else if (cnt_q != '0 && tmr_q < TW'(TMO)) begin
        tmr_d = tmr_q + TW'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        tmr_q <= '0;
      end else begin
        cnt_q <= cnt_d;
        tmr_q <= tmr_d;
      end
    end

    always_ff @(posedge clk) begin
      if (push_here) slots_q[int'(cnt_q)*EW +: EW] <= push_entry;
    end
  end
endmodule

// File: rtl/remote_word_proxy.sv
`timescale 1ns/1ps
module remote_word_proxy
  import rwp_pkg::*;
#(
  parameter int AW    = 30,
  parameter int DW    = 64,
  parameter int NB    = 2,
  parameter int DEPTH = 4,
  parameter int BATCH = 2,
  parameter int TMO   = 8,
  parameter int TAGW  = $clog2(DEPTH),
  parameter int CW    = $clog2(BATCH + 1),
  parameter int EW    = 1 + TAGW + (AW - 2 - NB) + DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [AW-1:0]       cpu_addr,
  input  logic [DW-1:0]       cpu_wdata,
  output logic                cpu_ack,
  output logic                cpu_err,
  output logic [DW-1:0]       cpu_rdata,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [NB-1:0]       tx_node,
  output logic [CW-1:0]       tx_count,
  output logic [BATCH*EW-1:0] tx_words,
  input  logic                rx_valid,
  input  logic [TAGW-1:0]     rx_tag,
  input  logic [DW-1:0]       rx_data
);
  localparam int GW    = AW - 2;
  localparam int OFFW  = GW - NB;
  localparam int NODES = 1 << NB;

  rwp_cmd_e         dec_cmd;
  logic [GW-1:0]    dec_gword;
  logic [NB-1:0]    dec_node;
  logic [OFFW-1:0]  dec_offs;
  logic             tbl_full, tbl_hit, tbl_done;
  logic [TAGW-1:0]  tbl_alloc, tbl_hit_idx;
  logic [DW-1:0]    tbl_data;
  logic [NODES-1:0] node_pend;
  logic             is_issue, is_cmpl, is_bad, issue_ok, cmpl_ok, cmpl_miss;
  logic [EW-1:0]    new_entry;

  rwp_decode #(.AW(AW), .NB(NB)) u_dec (
    .addr(cpu_addr), .cmd(dec_cmd), .gword(dec_gword),
    .node(dec_node), .offs(dec_offs)
  );

  assign is_issue  = cpu_req && (dec_cmd == CMD_ISSUE);
  assign is_cmpl   = cpu_req && (dec_cmd == CMD_COMPLETE);
  assign is_bad    = cpu_req && !is_issue && !is_cmpl;
  assign issue_ok  = is_issue && !tbl_full && !node_pend[dec_node];
  assign cmpl_ok   = is_cmpl && tbl_hit && tbl_done;
  assign cmpl_miss = is_cmpl && !tbl_hit;

  assign cpu_ack   = issue_ok || cmpl_ok || cmpl_miss || is_bad;
  assign cpu_err   = cmpl_miss || is_bad;
  assign cpu_rdata = (cmpl_ok && !cpu_we) ? tbl_data : '0;
  assign new_entry = {cpu_we, tbl_alloc, dec_offs, (cpu_we ? cpu_wdata : {DW{1'b0}})};

  rwp_table #(.DEPTH(DEPTH), .GW(GW), .DW(DW), .TAGW(TAGW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(issue_ok), .alloc_addr(dec_gword),
    .free_en(cmpl_ok), .free_idx(tbl_hit_idx),
    .rsp_en(rx_valid), .rsp_tag(rx_tag), .rsp_data(rx_data),
    .look_addr(dec_gword),
    .full(tbl_full), .alloc_idx(tbl_alloc),
    .hit(tbl_hit), .hit_idx(tbl_hit_idx), .hit_done(tbl_done), .hit_data(tbl_data)
  );

  rwp_batcher #(.NB(NB), .BATCH(BATCH), .TMO(TMO), .EW(EW), .NODES(NODES), .CW(CW)) u_batch (
    .clk(clk), .rst_n(rst_n),
    .push_en(issue_ok), .push_node(dec_node), .push_entry(new_entry),
    .tx_ready(tx_ready), .pend(node_pend),
    .tx_valid(tx_valid), .tx_node(tx_node), .tx_count(tx_count), .tx_words(tx_words)
  );
endmodule

// File: rtl/rwp_checker.sv
`timescale 1ns/1ps
module rwp_checker #(
  parameter int AW    = 30,
  parameter int NB    = 2,
  parameter int BATCH = 2,
  parameter int CW    = 2,
  parameter int WW    = 186
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_ack,
  input logic          cpu_err,
  input logic          tbl_full,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [NB-1:0] tx_node,
  input logic [CW-1:0] tx_count,
  input logic [WW-1:0] tx_words
);
  a_r2_bad_cmd_err: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && (cpu_addr[AW-1:AW-2] == 2'b00 || cpu_addr[AW-1:AW-2] == 2'b11)
      |-> cpu_ack && cpu_err);

  a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> cpu_req);

  a_r8_full_holds_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_addr[AW-1:AW-2] == 2'b01 && tbl_full |-> !cpu_ack);

  a_r9_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_count != '0) && (tx_count <= CW'(BATCH)));

  a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_node) && $stable(tx_count) && $stable(tx_words));
endmodule

bind remote_word_proxy rwp_checker #(
  .AW(AW), .NB(NB), .BATCH(BATCH), .CW(CW), .WW(BATCH*EW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_ack(cpu_ack), .cpu_err(cpu_err), .tbl_full(tbl_full),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_node(tx_node),
  .tx_count(tx_count), .tx_words(tx_words)
);

// File: tb/sim_remote_word_proxy.sv
`timescale 1ns/1ps
module sim_remote_word_proxy;
  localparam int AW = 30, DW = 64, NB = 2, DEPTH = 4, BATCH = 2, TMO = 8;
  localparam int TAGW = 2, CW = 2, OFFW = AW - 2 - NB, EW = 1 + TAGW + OFFW + DW;

  logic clk = 1'b0;
  logic rst_n, cpu_req, cpu_we, cpu_ack, cpu_err, tx_valid, tx_ready, rx_valid;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, rx_data;
  logic [NB-1:0] tx_node;
  logic [CW-1:0] tx_count;
  logic [BATCH*EW-1:0] tx_words;
  logic [TAGW-1:0] rx_tag;

  int n_chk = 0, n_fail = 0;
  logic s_ack, s_err;
  logic [DW-1:0] s_rd;

  always #10 clk = ~clk;

  remote_word_proxy u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_node(tx_node), .tx_count(tx_count),
    .tx_words(tx_words), .rx_valid(rx_valid), .rx_tag(rx_tag), .rx_data(rx_data)
  );

  // vector: {cmd, we, gword}; every one expects an immediate error response
  typedef struct packed { logic [1:0] cmd; logic we; logic [27:0] gw; } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'b00, 1'b0, 28'd21},  '{2'b11, 1'b1, 28'd5},
    '{2'b00, 1'b1, 28'hFFFFFFF}, '{2'b11, 1'b0, 28'd0},
    '{2'b10, 1'b0, 28'd21},  '{2'b10, 1'b1, 28'd37}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [EW-1:0] ent(logic we, logic [1:0] tag, logic [OFFW-1:0] off, logic [DW-1:0] d);
    return {we, tag, off, d};
  endfunction

  function automatic logic [27:0] gwa(int node, int off);
    return 28'((off << NB) | node);
  endfunction

  task automatic do_access(input logic [1:0] cmd, input logic we, input logic [27:0] gw, input logic [DW-1:0] wd);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = {cmd, gw}; cpu_wdata = wd;
    #1;
    s_ack = cpu_ack; s_err = cpu_err; s_rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic reply(input logic [TAGW-1:0] tag, input logic [DW-1:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_tag = tag; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_tag = '0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 tx_valid", tx_valid, 0);
    check("R1 cpu_ack", cpu_ack, 0);

    // table of reserved commands and completes to an empty table
    for (int v = 0; v < 6; v++) begin
      do_access(VECS[v].cmd, VECS[v].we, VECS[v].gw, 64'h1234);
      check((VECS[v].cmd == 2'b10) ? "R7 ack" : "R2 ack", s_ack, 1);
      check((VECS[v].cmd == 2'b10) ? "R7 err" : "R2 err", s_err, 1);
    end
    repeat (TMO + 2) @(negedge clk);
    #1 check("R2 nothing launched", tx_valid, 0);

    // full batch for node 1: read then write
    do_access(2'b01, 1'b0, gwa(1, 5), 64'hDEAD);
    check("R3 ack", s_ack, 1); check("R3 err", s_err, 0); check("R3 rdata", s_rd, 0);
    do_access(2'b01, 1'b1, gwa(1, 9), 64'hA5A5_0000_1111_2222);
    check("R3 ack2", s_ack, 1);
    #1;
    check("R9 tx_valid", tx_valid, 1);
    check("R9 tx_count", tx_count, BATCH);
    check("R4 tx_node", tx_node, 1);
    check("R4 slot0", tx_words[0 +: EW], ent(1'b0, 2'd0, 26'd5, 64'd0));
    check("R4 slot1", tx_words[EW +: EW], ent(1'b1, 2'd1, 26'd9, 64'hA5A5_0000_1111_2222));
    do_access(2'b01, 1'b0, gwa(1, 3), 64'd0);
    check("R12 pending node holds issue", s_ack, 0);
    repeat (3) @(negedge clk);
    #1;
    check("R12 hold count", tx_count, BATCH);
    check("R12 hold slot1", tx_words[EW +: EW], ent(1'b1, 2'd1, 26'd9, 64'hA5A5_0000_1111_2222));
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    #1 check("R12 flushed", tx_valid, 0);

    // read complete stalls; wrong-tag reply does not release it
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = {2'b10, gwa(1, 5)};
    for (int i = 0; i < 3; i++) begin
      #1 check("R5 stall", cpu_ack, 0);
      @(negedge clk);
    end
    rx_valid = 1'b1; rx_tag = 2'd1; rx_data = 64'h0;
    #1 check("R11 stall during reply", cpu_ack, 0);
    @(negedge clk);
    rx_valid = 1'b0;
    #1 check("R11 other tag keeps stall", cpu_ack, 0);
    @(negedge clk);
    cpu_req = 1'b0;
    do_access(2'b10, 1'b1, gwa(1, 9), 64'd0);
    check("R6 ack", s_ack, 1); check("R6 err", s_err, 0); check("R6 rdata", s_rd, 0);
    reply(2'd0, 64'hCAFE_F00D_0123_4567);
    do_access(2'b10, 1'b0, gwa(1, 5), 64'd0);
    check("R5 ack", s_ack, 1); check("R5 err", s_err, 0);
    check("R5 rdata", s_rd, 64'hCAFE_F00D_0123_4567);
    do_access(2'b10, 1'b0, gwa(1, 5), 64'd0);
    check("R5 freed err", s_err, 1);

    // timeout flush for a single request on node 2
    tx_ready = 1'b1;
    do_access(2'b01, 1'b0, gwa(2, 7), 64'd0);
    check("R10 ack", s_ack, 1);
    repeat (TMO - 1) @(negedge clk);
    #1 check("R10 not yet", tx_valid, 0);
    @(negedge clk);
    #1;
    check("R10 at timeout", tx_valid, 1);
    check("R10 count", tx_count, 1);
    check("R4 node2 slot", tx_words[0 +: EW], ent(1'b0, 2'd0, 26'd7, 64'd0));
    reply(2'd0, 64'd0);
    do_access(2'b10, 1'b0, gwa(2, 7), 64'd0);
    check("R5 node2 done", s_ack, 1);

    // fill the table across all nodes with the network held off
    tx_ready = 1'b0;
    do_access(2'b01, 1'b0, gwa(3, 1), 64'd0);
    do_access(2'b01, 1'b0, gwa(1, 1), 64'd0);
    do_access(2'b01, 1'b0, gwa(2, 1), 64'd0);
    do_access(2'b01, 1'b0, gwa(0, 1), 64'd0);
    check("R8 fourth accepted", s_ack, 1);
    do_access(2'b01, 1'b0, gwa(0, 2), 64'd0);
    check("R8 full holds issue", s_ack, 0);
    repeat (TMO + 2) @(negedge clk);
    #1;
    check("R12 held oldest node", tx_node, 3);
    tx_ready = 1'b1;
    @(negedge clk);
    #1 check("R12 lowest next", tx_node, 0);
    repeat (4) @(negedge clk);
    #1 check("R12 all sent", tx_valid, 0);
    reply(2'd2, 64'd0);
    do_access(2'b10, 1'b0, gwa(2, 1), 64'd0);
    check("R8 free via complete", s_ack, 1);
    do_access(2'b01, 1'b0, gwa(0, 2), 64'd0);
    check("R8 issue after free", s_ack, 1);
    repeat (TMO - 1) @(negedge clk);
    #1;
    check("R4 reused tag", tx_words[0 +: EW], ent(1'b0, 2'd2, 26'd2, 64'd0));
    check("R4 reused node", tx_node, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule